// File: doc/BRIEF.md
# Button Matrix Select Register

This block presents eight push buttons to a CPU as two banks of four, read through a single byte. The CPU writes a two-bit bank selector into the register. A read then returns that selector and the four buttons of the chosen bank in the low nibble. A pressed button reads as 0 and a released one as 1. The two top bits of the byte always read as 1. When the selector names no bank, or names both banks, the low nibble reads as all ones.

The raw button vector is active high. Bits 3:0 form bank A and bits 7:4 form bank B. The vector passes through a flop synchronizer before it reaches the multiplexer, so the buttons may change at any time. The read byte is combinational from the stored selector and the synchronized buttons. A CPU can therefore sample it in any cycle without a request strobe.

Top module: `btn_matrix_sel`

## Requirements
- R1: After reset the read byte is 8'hCF: selector 2'b00, no bank selected, and all button bits read 1.
- R2: Bits 7:6 of the read byte are 1 in every cycle, whatever is written.
- R3: A write stores wrData[5:4] as the selector. From the next cycle the read byte shows it in bits 5:4. Written bits 7:6 and 3:0 have no effect on the read byte.
- R4: With selector 2'b01 the low nibble equals the bitwise inverse of synchronized button bits 3:0.
- R5: With selector 2'b10 the low nibble equals the bitwise inverse of synchronized button bits 7:4.
- R6: With selector 2'b00 or 2'b11 the low nibble reads 4'hF for every button pattern.
- R7: A change on the button inputs reaches the read byte after exactly SYNC_STAGES rising clock edges, which is 2 by default, and not earlier.
- R8: Without a write the stored selector keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | CPU write strobe, one byte per cycle |
| wrData | input | 8 | CPU write byte; only bits 5:4 are kept |
| btnRaw | input | 8 | Asynchronous button levels, 1 = pressed |
| rdData | output | 8 | Read byte: 2'b11, selector, inverted bank |

## Verification
The bench builds the block with its default values: banks of four bits and a two-stage synchronizer. The synchronizer depth is small, so the bench can probe the read byte one edge after a button change and confirm it still shows the old value, then probe one edge later and see the new value. The four-bit bank width places both selector encodings and both idle encodings within reach of a few directed writes. The bench crosses each encoding with distinct button patterns, including all pressed and none pressed.

// File: rtl/btn_matrix_pkg.sv
package btn_matrix_pkg;
  localparam int GROUP_W    = 4;
  localparam int NUM_GROUPS = 2;
  localparam int BTN_W      = GROUP_W * NUM_GROUPS;
  localparam int SEL_W      = NUM_GROUPS;
  localparam int SEL_LSB    = GROUP_W;
  localparam int REG_W      = 8;
  localparam int FIXED_W    = REG_W - SEL_LSB - SEL_W;

  typedef struct packed {
    logic             selLoad;
    logic [SEL_W-1:0] selValue;
  } ctrlStrobes_t;
endpackage

// File: rtl/btn_matrix_ctrl.sv
module btn_matrix_ctrl
  import btn_matrix_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output ctrlStrobes_t     strobes
);
  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[REG_W-1:SEL_LSB+SEL_W], wrData[SEL_LSB-1:0]};

  always_comb begin
    strobes.selLoad  = wrEn;
    strobes.selValue = wrData[SEL_LSB +: SEL_W];
  end
endmodule

// File: rtl/btn_matrix_dp.sv
module btn_matrix_dp
  import btn_matrix_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [BTN_W-1:0] btnRaw,
  output logic [REG_W-1:0] rdData
);
  logic [SEL_W-1:0]   selReg;
  logic [BTN_W-1:0]   syncPipe [SYNC_STAGES];
  logic [BTN_W-1:0]   btnSync;
  logic [GROUP_W-1:0] groupBits [NUM_GROUPS];
  logic [GROUP_W-1:0] pressedSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) selReg <= '0;
    else if (strobes.selLoad) selReg <= strobes.selValue;
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncPipe[s] <= '0;
        else if (s == 0) syncPipe[s] <= btnRaw;
        else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign btnSync = syncPipe[SYNC_STAGES-1];

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_group
      assign groupBits[g] = (selReg == SEL_W'(1 << g)) ?
                            btnSync[g*GROUP_W +: GROUP_W] : '0;
    end
  endgenerate

  always_comb begin
    pressedSel = '0;
    for (int k = 0; k < NUM_GROUPS; k++) pressedSel = pressedSel | groupBits[k];
  end

  assign rdData = {{FIXED_W{1'b1}}, selReg, ~pressedSel};
endmodule

// File: rtl/btn_matrix_sel.sv
module btn_matrix_sel
  import btn_matrix_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic [BTN_W-1:0] btnRaw,
  output logic [REG_W-1:0] rdData
);
  ctrlStrobes_t strobes;

  btn_matrix_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strobes (strobes)
  );

  btn_matrix_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .btnRaw  (btnRaw),
    .rdData  (rdData)
  );
endmodule

// File: rtl/btn_matrix_sel_check.sv
module btn_matrix_sel_check
  import btn_matrix_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic [BTN_W-1:0] btnRaw,
  input logic [REG_W-1:0] rdData
);
  logic [BTN_W-1:0] delayed [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) delayed[i] <= '0;
    end else begin
      delayed[0] <= btnRaw;
      for (int i = 1; i < SYNC_STAGES; i++) delayed[i] <= delayed[i-1];
    end
  end

  p_fixed_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdData[7:6] == 2'b11);

  p_sel_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> rdData[5:4] == $past(wrData[5:4]));

  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(rdData[5:4]));

  p_bank_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData[5:4] == 2'b01) |-> rdData[3:0] == ~delayed[SYNC_STAGES-1][3:0]);

  p_bank_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData[5:4] == 2'b10) |-> rdData[3:0] == ~delayed[SYNC_STAGES-1][7:4]);

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData[5:4] == 2'b00 || rdData[5:4] == 2'b11) |-> rdData[3:0] == 4'hF);
endmodule

bind btn_matrix_sel btn_matrix_sel_check #(.SYNC_STAGES(SYNC_STAGES)) u_check (
  .clk    (clk),
  .rst_n  (rst_n),
  .wrEn   (wrEn),
  .wrData (wrData),
  .btnRaw (btnRaw),
  .rdData (rdData)
);

// File: tb/btn_matrix_sel_test.sv
module btn_matrix_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] btnRaw = 8'h00;
  logic [7:0] rdData;
  int checks = 0;
  int errors = 0;
  logic [1:0] curSel = 2'b00;

  always #2 clk = ~clk;

  btn_matrix_sel uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn),
    .wrData(wrData), .btnRaw(btnRaw), .rdData(rdData)
  );

  function automatic logic [7:0] expect_byte(logic [1:0] sel, logic [7:0] b);
    logic [3:0] low;
    case (sel)
      2'b01:   low = ~b[3:0];
      2'b10:   low = ~b[7:4];
      default: low = 4'hF;
    endcase
    return {2'b11, sel, low};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write_sel(logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = 8'h00;
    curSel = d[5:4];
  endtask

  task automatic set_buttons(logic [7:0] b);
    @(negedge clk); btnRaw = b;
    repeat (2) @(negedge clk);
  endtask

  task automatic test_reset;
    check("R1 reset byte", rdData, 8'hCF);
    btnRaw = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 no bank after reset", rdData, 8'hCF);
  endtask

  task automatic test_bank_a;
    write_sel(8'h10);
    foreach (patA[i]) begin
      set_buttons(patA[i]);
      check("R4 bank A", rdData, expect_byte(2'b01, patA[i]));
    end
  endtask

  task automatic test_bank_b;
    write_sel(8'h20);
    foreach (patA[i]) begin
      set_buttons(patA[i]);
      check("R5 bank B", rdData, expect_byte(2'b10, patA[i]));
    end
  endtask

  task automatic test_idle;
    write_sel(8'h00);
    set_buttons(8'hA5);
    check("R6 sel 00", rdData, 8'hCF);
    write_sel(8'h30);
    check("R6 sel 11", rdData, 8'hFF);
    set_buttons(8'h5A);
    check("R6 sel 11 other pattern", rdData, 8'hFF);
  endtask

  task automatic test_write_mask;
    set_buttons(8'h3C);
    write_sel(8'hCF);
    check("R3 masked bits, sel 00", rdData, expect_byte(2'b00, 8'h3C));
    write_sel(8'h1F);
    check("R3 sel 01 with junk", rdData, expect_byte(2'b01, 8'h3C));
    check("R2 fixed ones", rdData & 8'hC0, 8'hC0);
    write_sel(8'hE0);
    check("R3 sel 10 with junk", rdData, expect_byte(2'b10, 8'h3C));
    write_sel(8'h00);
    check("R2 fixed ones after zero write", rdData & 8'hC0, 8'hC0);
  endtask

  task automatic test_latency;
    write_sel(8'h10);
    set_buttons(8'h00);
    @(negedge clk); btnRaw = 8'h0F;
    @(negedge clk);
    check("R7 one edge, old value", rdData, expect_byte(2'b01, 8'h00));
    @(negedge clk);
    check("R7 two edges, new value", rdData, expect_byte(2'b01, 8'h0F));
  endtask

  task automatic test_hold;
    write_sel(8'h20);
    set_buttons(8'h90);
    repeat (5) @(negedge clk);
    check("R8 selector held", rdData, expect_byte(2'b10, 8'h90));
    btnRaw = 8'h09;
    repeat (4) @(negedge clk);
    check("R8 selector held, new buttons", rdData, expect_byte(2'b10, 8'h09));
  endtask

  logic [7:0] patA [4] = '{8'h00, 8'hFF, 8'h69, 8'h96};

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 byte after release", rdData, 8'hCF);
    test_bank_a();
    test_bank_b();
    test_idle();
    test_write_mask();
    test_latency();
    test_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule